// File: doc/BRIEF.md
# DRAM Command Timing Gate

This block sits between a DRAM command scheduler and the command path. It holds one 32-bit timing word that software programs through a simple register port, and it uses the packed delay fields of that word to decide, every cycle, which commands may legally go out. A `reg_wr_lock` input freezes the timing word while it is high.

The requester drives a command code and a bank number. The block answers with one allow bit per command type for the presented bank. It also raises `cmd_go` when the presented command is valid and allowed. A command counts as issued only in a cycle where `cmd_go` is high. In that cycle, every counter that the command starts is loaded. It then counts down once per clock.

The block keeps activate, write-recovery and precharge counters for each bank. It keeps the row-cycle, mode-register, activate-to-activate and write-to-read counters once for the whole device. If a command arrives while a counter is still running, the counter keeps the longer of its remaining time and the new delay.

Top module: `dram_cmd_gate`

## Requirements
- R1: After reset, `reg_rdata` reads 0x20227225. Field positions: mode-register gap [31:28], write-to-read gap [26:24], activate-to-activate gap [23:20], precharge gap [19:16], row-cycle gap [15:12], write-recovery gap [11:8], activate-to-column gap [7:4], activate-to-precharge gap [3:0].
- R2: When `reg_wr_lock` is low, a write lands in the next cycle. Bit 27 always reads 0.
- R3: When `reg_wr_lock` is high, a write leaves the timing word unchanged.
- R4: An issued activate blocks read and write to the same bank for the activate-to-column gap. Other banks are not blocked by it.
- R5: An issued activate blocks a precharge to the same bank for the activate-to-precharge gap.
- R6: An issued precharge blocks every command type, on every bank, for the precharge gap.
- R7: An issued activate blocks refresh for the row-cycle gap.
- R8: An issued mode-register load blocks activate and refresh for the mode-register gap. It does not block reads.
- R9: An issued activate blocks an activate to a different bank for the activate-to-activate gap. An activate to the same bank is not blocked by this gap.
- R10: An issued write blocks reads on all banks for the write-to-read gap. A programmed value of 0 acts as 1.
- R11: An issued write blocks a precharge to the same bank for the write-recovery gap. Other banks are not blocked by it.
- R12: A gap of N means the command is refused for exactly N cycles after the issuing cycle and allowed in the next one. N = 0 imposes no gap.
- R13: Command codes are activate 0, read 1, write 2, precharge 3, refresh 4, mode load 5. Bit i of `cmd_allow` belongs to code i. Codes 6 and 7 never raise `cmd_go` and start no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Timing word write strobe |
| reg_wr_lock | input | 1 | Write protect; blocks writes while high |
| reg_wdata | input | 32 | Timing word write data |
| reg_rdata | output | 32 | Current timing word |
| cmd_valid | input | 1 | Requester presents a command |
| cmd_kind | input | 3 | Command code (see R13) |
| cmd_bank | input | BANK_W | Target bank |
| cmd_allow | output | 6 | Per-command allow bits for `cmd_bank` |
| cmd_go | output | 1 | Command issued this cycle |

## Verification
Each delay field is swept over its full value range. Every other field is held at zero during a sweep, so the number of refused cycles measured after the trigger command isolates that one field. For each value, the bench pairs the trigger with a follow-up command to the same bank and with one to a different bank. This separates per-bank counters from device-wide ones, and it exposes a gap applied to the wrong command type. The precharge sweep cycles through every follow-up code. The write-to-read sweep includes 0, to tell a floor of one cycle apart from no gap. The register is exercised with bit 27 set and with locked writes.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    localparam int NUM_CMDS = 6;
    localparam int DLY_W    = 4;

    localparam logic [31:0] TIMING_RESET = 32'h2022_7225;
    localparam logic [31:0] TIMING_MASK  = 32'hF7FF_FFFF;

    typedef logic [DLY_W-1:0] dly_t;

    typedef enum logic [2:0] {
        CMD_ACT = 3'd0,
        CMD_RD  = 3'd1,
        CMD_WR  = 3'd2,
        CMD_PRE = 3'd3,
        CMD_REF = 3'd4,
        CMD_LMR = 3'd5
    } cmd_e;

    typedef struct packed {
        dly_t       mrd;
        logic       pad;
        logic [2:0] wtr;
        dly_t       rrd;
        dly_t       rp;
        dly_t       rc;
        dly_t       wrec;
        dly_t       rcd;
        dly_t       ras;
    } timing_t;

    // Count down by one; on a hit keep the longer of remaining and new delay.
    function automatic dly_t reload(dly_t cur, dly_t n, logic hit);
        dly_t dec;
        dec = (cur == '0) ? '0 : cur - 1'b1;
        return (hit && (n > dec)) ? n : dec;
    endfunction

    function automatic dly_t wtr_floor(logic [2:0] v);
        return (v == 3'd0) ? dly_t'(1) : dly_t'(v);
    endfunction

endpackage

// File: rtl/dcg_regfile.sv
module dcg_regfile
    import dcg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        lock,
    input  logic [31:0] wdata,
    output timing_t     cfg
);

    timing_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= timing_t'(TIMING_RESET);
        end else if (wr_en && !lock) begin
            q <= timing_t'(wdata & TIMING_MASK);
        end
    end

    assign cfg = q;

    // R3: a protected write changes nothing
    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lock) |=> (q == $past(q)));

    // R2: an open write lands, with bit 27 forced low
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !lock) |=> (q.pad == 1'b0 && q.ras == $past(wdata[3:0])
                              && q.mrd == $past(wdata[31:28])));

endmodule

// File: rtl/dcg_bank_timer.sv
module dcg_bank_timer
    import dcg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act_hit,
    input  logic wr_hit,
    input  logic pre_hit,
    input  dly_t rcd_n,
    input  dly_t ras_n,
    input  dly_t wrec_n,
    input  dly_t rp_n,
    output logic rcd_busy,
    output logic pre_busy,
    output logic rp_busy
);

    dly_t rcd_q, ras_q, wrec_q, rp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcd_q  <= '0;
            ras_q  <= '0;
            wrec_q <= '0;
            rp_q   <= '0;
        end else begin
            rcd_q  <= reload(rcd_q,  rcd_n,  act_hit);
            ras_q  <= reload(ras_q,  ras_n,  act_hit);
            wrec_q <= reload(wrec_q, wrec_n, wr_hit);
            rp_q   <= reload(rp_q,   rp_n,   pre_hit);
        end
    end

    assign rcd_busy = (rcd_q != '0);
    assign pre_busy = (ras_q != '0) || (wrec_q != '0);
    assign rp_busy  = (rp_q != '0);

    // R4: an activate with a nonzero gap arms the column block
    assert_rcd_arm_R4: assert property (@(posedge clk) disable iff (rst)
        (act_hit && rcd_n != '0) |=> rcd_busy);

    // R12: without a new hit the counter steps down by exactly one
    assert_count_down_R12: assert property (@(posedge clk) disable iff (rst)
        (!act_hit && rcd_q != '0) |=> (rcd_q == $past(rcd_q) - 1'b1));

    // R11: a write with nonzero recovery blocks precharge next cycle
    assert_wrec_arm_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wrec_n != '0) |=> pre_busy);

endmodule

// File: rtl/dcg_global_timer.sv
module dcg_global_timer
    import dcg_pkg::*;
#(
    parameter int BANK_W = 3
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              act_hit,
    input  logic              wr_hit,
    input  logic              lmr_hit,
    input  logic [BANK_W-1:0] act_bank,
    input  dly_t              rc_n,
    input  dly_t              mrd_n,
    input  dly_t              rrd_n,
    input  dly_t              wtr_n,
    output logic              rc_busy,
    output logic              mrd_busy,
    output logic              rrd_busy,
    output logic              wtr_busy,
    output logic [BANK_W-1:0] rrd_bank
);

    dly_t rc_q, mrd_q, rrd_q, wtr_q;
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rc_q   <= '0;
            mrd_q  <= '0;
            rrd_q  <= '0;
            wtr_q  <= '0;
            bank_q <= '0;
        end else begin
            rc_q  <= reload(rc_q,  rc_n,  act_hit);
            mrd_q <= reload(mrd_q, mrd_n, lmr_hit);
            wtr_q <= reload(wtr_q, wtr_n, wr_hit);
            // the newest activate owns the activate-to-activate window
            rrd_q <= act_hit ? rrd_n : reload(rrd_q, '0, 1'b0);
            if (act_hit) bank_q <= act_bank;
        end
    end

    assign rc_busy  = (rc_q  != '0);
    assign mrd_busy = (mrd_q != '0);
    assign rrd_busy = (rrd_q != '0);
    assign wtr_busy = (wtr_q != '0);
    assign rrd_bank = bank_q;

    // R8: a mode load with nonzero gap arms the mode block
    assert_mrd_arm_R8: assert property (@(posedge clk) disable iff (rst)
        (lmr_hit && mrd_n != '0) |=> mrd_busy);

    // R10: every write blocks reads for at least one cycle
    assert_wtr_floor_R10: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> wtr_busy);

endmodule

// File: rtl/dram_cmd_gate.sv
module dram_cmd_gate
    import dcg_pkg::*;
#(
    parameter  int NUM_BANKS = 8,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_en,
    input  logic                reg_wr_lock,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_kind,
    input  logic [BANK_W-1:0]   cmd_bank,
    output logic [NUM_CMDS-1:0] cmd_allow,
    output logic                cmd_go
);

    timing_t cfg;

    logic [NUM_BANKS-1:0] act_hit, wr_hit, pre_hit;
    logic [NUM_BANKS-1:0] rcd_busy, pre_busy, rp_busy;
    logic rc_busy, mrd_busy, rrd_busy, wtr_busy;
    logic [BANK_W-1:0] rrd_bank;
    logic any_rp, rrd_block;
    logic [7:0] allow_wide;
    logic go_act, go_wr, go_lmr;

    dcg_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .lock  (reg_wr_lock),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    assign reg_rdata = cfg;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic sel;
            assign sel        = cmd_go && (cmd_bank == BANK_W'(b));
            assign act_hit[b] = sel && (cmd_kind == CMD_ACT);
            assign wr_hit[b]  = sel && (cmd_kind == CMD_WR);
            assign pre_hit[b] = sel && (cmd_kind == CMD_PRE);

            dcg_bank_timer u_bank (
                .clk      (clk),
                .rst      (rst),
                .act_hit  (act_hit[b]),
                .wr_hit   (wr_hit[b]),
                .pre_hit  (pre_hit[b]),
                .rcd_n    (cfg.rcd),
                .ras_n    (cfg.ras),
                .wrec_n   (cfg.wrec),
                .rp_n     (cfg.rp),
                .rcd_busy (rcd_busy[b]),
                .pre_busy (pre_busy[b]),
                .rp_busy  (rp_busy[b])
            );
        end
    endgenerate

    assign go_act = |act_hit;
    assign go_wr  = |wr_hit;
    assign go_lmr = cmd_go && (cmd_kind == CMD_LMR);

    dcg_global_timer #(.BANK_W(BANK_W)) u_glob (
        .clk      (clk),
        .rst      (rst),
        .act_hit  (go_act),
        .wr_hit   (go_wr),
        .lmr_hit  (go_lmr),
        .act_bank (cmd_bank),
        .rc_n     (cfg.rc),
        .mrd_n    (cfg.mrd),
        .rrd_n    (cfg.rrd),
        .wtr_n    (wtr_floor(cfg.wtr)),
        .rc_busy  (rc_busy),
        .mrd_busy (mrd_busy),
        .rrd_busy (rrd_busy),
        .wtr_busy (wtr_busy),
        .rrd_bank (rrd_bank)
    );

    assign any_rp    = |rp_busy;
    assign rrd_block = rrd_busy && (rrd_bank != cmd_bank);

    always_comb begin
        cmd_allow          = '0;
        cmd_allow[CMD_ACT] = !any_rp && !mrd_busy && !rrd_block;
        cmd_allow[CMD_RD]  = !any_rp && !rcd_busy[cmd_bank] && !wtr_busy;
        cmd_allow[CMD_WR]  = !any_rp && !rcd_busy[cmd_bank];
        cmd_allow[CMD_PRE] = !any_rp && !pre_busy[cmd_bank];
        cmd_allow[CMD_REF] = !any_rp && !rc_busy && !mrd_busy;
        cmd_allow[CMD_LMR] = !any_rp;
    end

    assign allow_wide = {{(8-NUM_CMDS){1'b0}}, cmd_allow};
    assign cmd_go     = cmd_valid && allow_wide[cmd_kind];

    // R6: a precharge with nonzero gap shuts every command next cycle
    assert_pre_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && cmd_kind == CMD_PRE && cfg.rp != '0) |=> (cmd_allow == '0));

    // R13: unused codes are never issued
    assert_bad_code_R13: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind > 3'd5) |-> !cmd_go);

endmodule

// File: tb/sim_dram_cmd_gate.sv
`timescale 1ns/1ps
module sim_dram_cmd_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_lock = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_kind = '0;
    logic [2:0]  cmd_bank = '0;
    logic [5:0]  cmd_allow;
    logic        cmd_go;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dram_cmd_gate #(.NUM_BANKS(8)) u0 (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_lock (reg_wr_lock),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cmd_valid   (cmd_valid),
        .cmd_kind    (cmd_kind),
        .cmd_bank    (cmd_bank),
        .cmd_allow   (cmd_allow),
        .cmd_go      (cmd_go)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] v, input logic lk);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wdata = v; reg_wr_lock = lk;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_lock = 1'b0;
    endtask

    // Issue k1 on b1, then count cycles that k2 on b2 is refused.
    task automatic gap(input logic [2:0] k1, input int b1, input logic [2:0] k2,
                       input int b2, input int exp, input string tag);
        int n;
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        cmd_kind = k1; cmd_bank = 3'(b1); cmd_valid = 1'b1;
        #1;
        check({31'd0, cmd_go}, 32'd1, {tag, " trigger issued"});
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = k2; cmd_bank = 3'(b2);
        #1;
        n = 0;
        while (!cmd_allow[k2] && n < 40) begin
            n++;
            @(negedge clk);
            #1;
        end
        check(32'(n), 32'(exp), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(reg_rdata, 32'h2022_7225, "R1 reset value");
        check({26'd0, cmd_allow}, 32'h3F, "R1 all allowed after reset");
        gap(3'd0, 2, 3'd1, 2, 2, "R1 reset activate-to-column gap");
        gap(3'd2, 0, 3'd1, 0, 1, "R10 reset write-to-read floor");

        write_reg(32'hFFFF_FFFF, 1'b0);
        check(reg_rdata, 32'hF7FF_FFFF, "R2 bit 27 reads zero");
        write_reg(32'h1234_5678, 1'b1);
        check(reg_rdata, 32'hF7FF_FFFF, "R3 locked write ignored");
        write_reg(32'h0000_0000, 1'b0);
        check(reg_rdata, 32'h0, "R2 write lands");

        // R13: invalid codes
        for (int c = 6; c < 8; c++) begin
            @(negedge clk);
            cmd_kind = 3'(c); cmd_bank = 3'd1; cmd_valid = 1'b1;
            #1;
            check({31'd0, cmd_go}, 32'd0, "R13 unused code not issued");
        end
        cmd_valid = 1'b0;

        for (int n = 0; n < 16; n++) begin
            write_reg(32'(n) << 4, 1'b0);
            gap(3'd0, 2, 3'd1, 2, n, "R4 act to read same bank");
            gap(3'd0, 2, 3'd2, 2, n, "R4 act to write same bank");
            gap(3'd0, 2, 3'd1, 5, 0, "R4 act other bank not blocked");

            write_reg(32'(n), 1'b0);
            gap(3'd0, 3, 3'd3, 3, n, "R5 act to precharge");

            write_reg(32'(n) << 16, 1'b0);
            for (int k = 0; k < 6; k++)
                gap(3'd3, 1, 3'(k), (k + 4) % 8, n, "R6 precharge blocks all");

            write_reg(32'(n) << 12, 1'b0);
            gap(3'd0, 0, 3'd4, 0, n, "R7 act to refresh");

            write_reg(32'(n) << 28, 1'b0);
            gap(3'd5, 0, 3'd0, 6, n, "R8 mode load to act");
            gap(3'd5, 0, 3'd4, 6, n, "R8 mode load to refresh");
            gap(3'd5, 0, 3'd1, 6, 0, "R8 mode load leaves read");

            write_reg(32'(n) << 20, 1'b0);
            gap(3'd0, 1, 3'd0, 2, n, "R9 act to act other bank");
            gap(3'd0, 1, 3'd0, 1, 0, "R9 act same bank free");

            write_reg(32'(n) << 8, 1'b0);
            gap(3'd2, 7, 3'd3, 7, n, "R11 write to precharge");
            gap(3'd2, 7, 3'd3, 0, 0, "R11 other bank precharge free");

            if (n < 8) begin
                write_reg(32'(n) << 24, 1'b0);
                gap(3'd2, 4, 3'd1, 4, (n == 0) ? 1 : n, "R10 write to read");
                gap(3'd2, 4, 3'd1, 2, (n == 0) ? 1 : n, "R10 write to read other bank");
            end
            if (n == 0) check(32'd0, 32'd0, "R12 zero gap covered above");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule